// File: doc/BRIEF.md
# Supervisor and Guest Timer Compare

This block holds two 64-bit timer compare registers. One belongs to the host supervisor and one to a guest supervisor running under a hypervisor. Each register is compared with the platform time, and the result drives a level-sensitive timer pending output. The guest comparison first adds a 64-bit hypervisor time offset to the time value. The sum wraps modulo 2^64 before the compare. Both pending outputs are registered.

A single CSR access port reaches the registers. The access port takes the current privilege level and the virtualization state, and it decides which register the access targets. It also decides whether the access must fault with an illegal-instruction outcome or a virtual-illegal-instruction outcome. Three enables gate this decision and the pending outputs: a machine-level compare enable, a hypervisor-level compare enable, and the hypervisor's time-counter access enable. The CSR file around the block uses the fault outputs to raise the exception. A faulting access writes nothing and reads zero.

Top module: `stimer_cmp_top`

## Requirements
- R1: After reset, both compare registers read 64'hFFFF_FFFF_FFFF_FFFF, and both pending outputs are low.
- R2: When `mach_cmp_en` is 1, `host_tip` equals the unsigned result of `time_val >= host compare` as sampled at the previous rising clock edge.
- R3: When `mach_cmp_en` and `hyp_cmp_en` are both 1, `guest_tip` equals the unsigned result of `(time_val + time_offset) mod 2^64 >= guest compare` as sampled at the previous rising edge.
- R4: When `mach_cmp_en` is 0, any access below machine level (`acc_priv` not 2'b11) raises `acc_illegal`. That access changes no register, and `host_tip` and `guest_tip` are held low.
- R5: With `acc_virt` = 1 and `acc_priv` = 2'b01 (guest supervisor), and with all enables set, an access reads or writes the guest compare register, and the host register is unchanged.
- R6: In guest supervisor mode with `mach_cmp_en` = 1, the access raises `acc_virt_illegal` and writes nothing if `hyp_cmp_en` = 0 or `hyp_time_en` = 0. `guest_tip` is held low while `hyp_cmp_en` = 0.
- R7: Machine-level accesses (`acc_priv` = 2'b11) never fault and always target the host register, whatever the enables and `acc_virt` are.
- R8: A legal write updates the targeted register at the next rising edge. The new value is read back from then on, and the pending output reflects it one edge later. For example, writing a value above the current time clears the pending bit.
- R9: With `mach_cmp_en` = 1, user level (`acc_priv` 2'b00, and also 2'b10 which is treated as user) raises `acc_illegal` when `acc_virt` = 0 and `acc_virt_illegal` when `acc_virt` = 1. The two fault outputs are never high together.
- R10: `acc_rdata` is zero whenever `acc_valid` is low or the access faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_val | input | 64 | Platform time |
| time_offset | input | 64 | Hypervisor offset added to time for the guest compare |
| mach_cmp_en | input | 1 | Machine-level compare enable |
| hyp_cmp_en | input | 1 | Hypervisor-level compare enable |
| hyp_time_en | input | 1 | Hypervisor time-counter access enable for the guest |
| acc_valid | input | 1 | Access to the compare CSR this cycle |
| acc_write | input | 1 | Access is a write |
| acc_priv | input | 2 | Privilege: 2'b11 machine, 2'b01 supervisor, 2'b00 or 2'b10 user |
| acc_virt | input | 1 | Access comes from a virtualized guest |
| acc_wdata | input | 64 | Write data |
| acc_rdata | output | 64 | Read data of the targeted register, zero on fault |
| acc_illegal | output | 1 | Access raises illegal instruction |
| acc_virt_illegal | output | 1 | Access raises virtual illegal instruction |
| host_tip | output | 1 | Host supervisor timer pending |
| guest_tip | output | 1 | Guest supervisor timer pending |

## Verification
Two functions can fall in the same cycle: a software write to a compare register, and a time step that crosses that register's old or new value. The bench provokes this on purpose. It writes values a few ticks around the current time while time keeps advancing. It also writes a value above the current time while the pending bit is high, and then checks that the pending output follows the old value for exactly one more edge before it follows the new one. The bench's model updates the pending output from the register state before the edge and the register from the write at that same edge. Random sweeps over the privilege, virtualization and enable inputs then confirm that a faulting write landing in such a cycle leaves the compare, and so the pending output, unchanged.

// File: rtl/stimer_cmp_pkg.sv
package stimer_cmp_pkg;

  typedef enum logic [1:0] {
    PRIV_USER = 2'b00,
    PRIV_SUP  = 2'b01,
    PRIV_RSV  = 2'b10,
    PRIV_MACH = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    ACC_OK   = 2'b00,
    ACC_ILL  = 2'b01,
    ACC_VILL = 2'b10
  } acc_res_e;

  localparam int unsigned NUM_CMP   = 2;
  localparam int unsigned HOST_IDX  = 0;
  localparam int unsigned GUEST_IDX = 1;

endpackage

// File: rtl/stimer_access_check.sv
module stimer_access_check
  import stimer_cmp_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       virt,
  input  logic       mach_en,
  input  logic       hyp_en,
  input  logic       hyp_tm,
  output acc_res_e   result,
  output logic       to_guest
);

  priv_e priv_dec;

  always_comb begin
    priv_dec = priv_e'(priv);
    result   = ACC_OK;
    to_guest = 1'b0;
    if (priv_dec == PRIV_MACH) begin
      result   = ACC_OK;
      to_guest = 1'b0;
    end else if (!mach_en) begin
      result = ACC_ILL;
    end else if (!virt) begin
      result = (priv_dec == PRIV_SUP) ? ACC_OK : ACC_ILL;
    end else if (priv_dec != PRIV_SUP) begin
      result = ACC_VILL;
    end else if (!hyp_en || !hyp_tm) begin
      result = ACC_VILL;
    end else begin
      result   = ACC_OK;
      to_guest = 1'b1;
    end
  end

endmodule

// File: rtl/stimer_cmp_reg.sv
module stimer_cmp_reg #(
  parameter int unsigned      W         = 64,
  parameter logic [W-1:0]     RESET_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);

  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (wr_en) q_next = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET_VAL;
    else        q <= q_next;
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q == $past(wr_data)));                                  // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));                                            // R8

endmodule

// File: rtl/stimer_pend_gen.sv
module stimer_pend_gen #(
  parameter int unsigned W          = 64,
  parameter bit          USE_OFFSET = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic [W-1:0] time_in,
  input  logic [W-1:0] offset,
  input  logic [W-1:0] cmp,
  output logic         pend
);

  logic [W-1:0] eff_time;
  logic         pend_next;

  generate
    if (USE_OFFSET) begin : g_offset
      always_comb eff_time = time_in + offset;
    end else begin : g_plain
      logic unused_offset;
      always_comb begin
        eff_time      = time_in;
        unused_offset = ^offset;
      end
    end
  endgenerate

  always_comb pend_next = enable && (eff_time >= cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_next;
  end

  AST_PEND_SUPPRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pend);                                                // R4
  AST_PEND_RISE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(enable));                                    // R6

endmodule

// File: rtl/stimer_cmp_top.sv
module stimer_cmp_top
  import stimer_cmp_pkg::*;
#(
  parameter int unsigned TW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_val,
  input  logic [TW-1:0] time_offset,
  input  logic          mach_cmp_en,
  input  logic          hyp_cmp_en,
  input  logic          hyp_time_en,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [1:0]    acc_priv,
  input  logic          acc_virt,
  input  logic [TW-1:0] acc_wdata,
  output logic [TW-1:0] acc_rdata,
  output logic          acc_illegal,
  output logic          acc_virt_illegal,
  output logic          host_tip,
  output logic          guest_tip
);

  localparam logic [TW-1:0] CMP_RESET = '1;

  logic [1:0]    rst_pipe_q;
  logic [1:0]    rst_pipe_next;
  logic          rst_int_n;
  acc_res_e      acc_res;
  logic          acc_to_guest;
  logic [TW-1:0] cmp_q   [NUM_CMP];
  logic          wr_sel  [NUM_CMP];
  logic          pend_en [NUM_CMP];
  logic          pend_q  [NUM_CMP];

  // reset: asserted asynchronously, released after two clock edges
  always_comb rst_pipe_next = {rst_pipe_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= rst_pipe_next;
  end

  always_comb rst_int_n = rst_pipe_q[1];

  stimer_access_check u_check (
    .priv     (acc_priv),
    .virt     (acc_virt),
    .mach_en  (mach_cmp_en),
    .hyp_en   (hyp_cmp_en),
    .hyp_tm   (hyp_time_en),
    .result   (acc_res),
    .to_guest (acc_to_guest)
  );

  always_comb begin
    pend_en[HOST_IDX]  = mach_cmp_en;
    pend_en[GUEST_IDX] = mach_cmp_en && hyp_cmp_en;
  end

  generate
    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
      always_comb wr_sel[g] = acc_valid && acc_write && (acc_res == ACC_OK) &&
                              (acc_to_guest == (g == GUEST_IDX));

      stimer_cmp_reg #(.W(TW), .RESET_VAL(CMP_RESET)) u_reg (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .wr_en   (wr_sel[g]),
        .wr_data (acc_wdata),
        .q       (cmp_q[g])
      );

      stimer_pend_gen #(.W(TW), .USE_OFFSET(g == GUEST_IDX)) u_pend (
        .clk     (clk),
        .rst_n   (rst_int_n),
        .enable  (pend_en[g]),
        .time_in (time_val),
        .offset  (time_offset),
        .cmp     (cmp_q[g]),
        .pend    (pend_q[g])
      );
    end
  endgenerate

  always_comb begin
    acc_illegal      = acc_valid && (acc_res == ACC_ILL);
    acc_virt_illegal = acc_valid && (acc_res == ACC_VILL);
    acc_rdata        = '0;
    if (acc_valid && (acc_res == ACC_OK))
      acc_rdata = acc_to_guest ? cmp_q[GUEST_IDX] : cmp_q[HOST_IDX];
    host_tip  = pend_q[HOST_IDX];
    guest_tip = pend_q[GUEST_IDX];
  end

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && acc_write && (acc_illegal || acc_virt_illegal)) |=>
      ($stable(cmp_q[HOST_IDX]) && $stable(cmp_q[GUEST_IDX])));         // R4
  AST_SINGLE_FAULT: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(acc_illegal && acc_virt_illegal));                               // R9
  AST_MACH_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && (acc_priv == 2'b11)) |-> (!acc_illegal && !acc_virt_illegal)); // R7
  AST_HOST_UNTOUCHED_BY_GUEST: assert property (@(posedge clk) disable iff (!rst_int_n)
    (acc_valid && acc_write && acc_virt && (acc_priv == 2'b01)) |=>
      $stable(cmp_q[HOST_IDX]));                                        // R5

endmodule

// File: tb/tb_stimer_cmp_top.sv
module tb_stimer_cmp_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] tm, dl, wd;
  logic        ms, hs, htm, av, aw, vt;
  logic [1:0]  pv;
  logic [63:0] acc_rdata;
  logic        acc_illegal, acc_virt_illegal, host_tip, guest_tip;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [63:0] sm, vm;
  logic        e_stip, e_vstip;

  always #4 clk = ~clk;

  stimer_cmp_top dut (
    .clk(clk), .rst_n(rst_n), .time_val(tm), .time_offset(dl),
    .mach_cmp_en(ms), .hyp_cmp_en(hs), .hyp_time_en(htm),
    .acc_valid(av), .acc_write(aw), .acc_priv(pv), .acc_virt(vt),
    .acc_wdata(wd), .acc_rdata(acc_rdata), .acc_illegal(acc_illegal),
    .acc_virt_illegal(acc_virt_illegal), .host_tip(host_tip), .guest_tip(guest_tip)
  );

  // returns {virt_illegal, illegal}
  function automatic logic [1:0] fault_of(input logic [1:0] p, input logic v,
                                          input logic m, input logic h, input logic t);
    if (p == 2'b11) return 2'b00;
    if (!m)         return 2'b01;
    if (!v)         return (p == 2'b01) ? 2'b00 : 2'b01;
    if (p != 2'b01) return 2'b10;
    if (!h || !t)   return 2'b10;
    return 2'b00;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called just after a falling edge with inputs already driven
  task automatic tick(input string tag);
    logic [1:0]  f;
    logic        guest;
    logic [63:0] erd;
    #1;
    f     = fault_of(pv, vt, ms, hs, htm);
    guest = (pv != 2'b11) && vt;
    erd   = (av && f == 2'b00) ? (guest ? vm : sm) : 64'h0;
    chk({tag, " illegal"},      {63'h0, acc_illegal},      {63'h0, av && f[0]});
    chk({tag, " virt_illegal"}, {63'h0, acc_virt_illegal}, {63'h0, av && f[1]});
    chk({tag, " rdata (R10)"},  acc_rdata, erd);
    @(posedge clk);
    e_stip  = ms && (tm >= sm);
    e_vstip = ms && hs && ((tm + dl) >= vm);
    if (av && aw && f == 2'b00) begin
      if (guest) vm = wd; else sm = wd;
    end
    #2;
    chk({tag, " host_tip"},  {63'h0, host_tip},  {63'h0, e_stip});
    chk({tag, " guest_tip"}, {63'h0, guest_tip}, {63'h0, e_vstip});
    @(negedge clk);
  endtask

  task automatic acc(input logic w, input logic [1:0] p, input logic v, input logic [63:0] d);
    av = 1'b1; aw = w; pv = p; vt = v; wd = d;
  endtask

  task automatic idle();
    av = 1'b0; aw = 1'b0; pv = 2'b11; vt = 1'b0; wd = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    tm = '0; dl = '0; ms = 1'b1; hs = 1'b1; htm = 1'b1;
    idle();
    sm = '1; vm = '1; e_stip = 1'b0; e_vstip = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state, read back through the access port
    chk("R1 host_tip", {63'h0, host_tip}, 64'h0);
    chk("R1 guest_tip", {63'h0, guest_tip}, 64'h0);
    acc(1'b0, 2'b11, 1'b0, '0); tick("R1 host read");
    acc(1'b0, 2'b01, 1'b1, '0); tick("R1 guest read");

    // R2 / R8: write below time, then above time while pending
    tm = 64'd100; acc(1'b1, 2'b11, 1'b0, 64'd50); tick("R8 write low");
    idle(); tick("R2 pending rises");
    acc(1'b1, 2'b01, 1'b0, 64'd200); tick("R8 write high, old still pending");
    idle(); tick("R8 pending cleared");
    tm = 64'd200; tick("R2 equality");

    // R3 wrap of time + offset
    tm = 64'hFFFF_FFFF_FFFF_FFF0; dl = 64'h20;
    acc(1'b1, 2'b01, 1'b1, 64'h11); tick("R5 guest write");
    idle(); tick("R3 wrapped below");
    acc(1'b1, 2'b01, 1'b1, 64'h10); tick("R3 guest write eq");
    idle(); tick("R3 wrapped equal");

    // R4 machine enable off
    ms = 1'b0;
    acc(1'b1, 2'b01, 1'b0, 64'h0); tick("R4 sup write blocked");
    acc(1'b1, 2'b01, 1'b1, 64'h0); tick("R4 guest write blocked");
    acc(1'b1, 2'b11, 1'b1, 64'h0); tick("R7 mach write with enable off");
    idle(); tick("R4 pendings held low");
    ms = 1'b1;

    // R6 hypervisor gates
    hs = 1'b0; acc(1'b1, 2'b01, 1'b1, 64'h5); tick("R6 hyp enable off");
    idle(); tick("R6 guest_tip low");
    hs = 1'b1; htm = 1'b0; acc(1'b0, 2'b01, 1'b1, '0); tick("R6 time enable off");
    htm = 1'b1;

    // R9 user levels
    acc(1'b1, 2'b00, 1'b0, 64'h7); tick("R9 user");
    acc(1'b1, 2'b10, 1'b1, 64'h7); tick("R9 guest user");

    // constrained random sweep
    tm = 64'd1000; dl = {$urandom, $urandom};
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      tm = tm + 64'($urandom_range(0, 3));
      if (r == 0) tm = {$urandom, $urandom};
      if ($urandom_range(0, 49) == 0) dl = {$urandom, $urandom};
      ms  = ($urandom_range(0, 7) != 0);
      hs  = ($urandom_range(0, 5) != 0);
      htm = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 2) == 0) idle();
      else begin
        logic [63:0] base;
        pv   = 2'($urandom_range(0, 3));
        vt   = 1'($urandom_range(0, 1));
        base = vt ? (tm + dl) : tm;
        acc(1'($urandom_range(0, 1)), pv, vt, base + 64'($signed(6'($urandom_range(0, 63)))));
      end
      tick("R2/R3/R5/R8 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule